// File: doc/BRIEF.md
# One-Shot Masked Port Change Detector

This block watches a group of seven general-purpose port pins and reports when any of the enabled ones moves away from a reference copy. Software arms it by writing the configuration register with the arm bit set. That write stores the present pin levels as a snapshot and clears any earlier status. While armed, every synchronized sample of the pins is compared against the snapshot through a per-pin enable mask. The first mismatch sets a sticky status bit and ends detection for this arming.

The status bit is cleared by any access to the mask register, whether a read or a write. A read returns the status before it is cleared. Detection stays off after such an event until the arm bit is written again. When the interrupt pin is configured as an output, it carries the status bit as an active-high request. Otherwise it carries its ordinary output latch value. The register bus is represented here only by the strobes and data that the block needs.

Top module: `chg_watch`

## Requirements
- R1: After reset the status bit is 0, detection is disarmed, every mask bit is 0, and `msk_rdata_o` reads 0x00.
- R2: Port pins pass through two synchronizing flops. A change driven just after one rising clock edge first appears on `status_o` after the third following rising edge. A change held for one clock period is still caught.
- R3: A configuration write with the arm bit set (`cfg_wr_i` and `cfg_m_i`) does three things: it stores the synchronized pin levels as the snapshot, arms detection and clears the status bit. It does this even if detection is already armed.
- R4: A configuration write with the arm bit clear disarms detection. Later pin changes do not set the status bit.
- R5: While armed, the status bit is set by any pin `port_i[i]` whose enable `mask[i]` is 1 and whose synchronized level differs from its snapshot bit. Pins whose mask bit is 0 never set it. Mask bit i belongs to `port_i[i]`.
- R6: Once set, the status bit stays set through further pin changes, including a return of the pins to their snapshot levels, until it is cleared.
- R7: `msk_rdata_o` is {status, mask[6:0]}. A read or write of the mask register clears the status at the next clock edge, so two back-to-back reads after an event return bit 7 as 1 and then as 0.
- R8: Bit 7 of `msk_wdata_i` is not stored, and writing it as 1 never sets the status bit.
- R9: Detection is one-shot. After an event, pin changes do not set the status again until another arming write.
- R10: `p31_o` equals the status bit when `p31_out_en_i` is 1, and equals `p31_latch_i` otherwise.
- R11: Same-cycle priority: an arming write wins over a detection, and a detection wins over a disarming write or a mask access. A detection that coincides with a mask access therefore leaves the status set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 7 | Monitored pin levels, asynchronous |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_m_i | input | 1 | Arm bit of the configuration write data |
| msk_wr_i | input | 1 | Mask register write strobe |
| msk_rd_i | input | 1 | Mask register read strobe |
| msk_wdata_i | input | 8 | Mask register write data, bits 6:0 are enables |
| msk_rdata_o | output | 8 | Mask register read data {status, mask} |
| status_o | output | 1 | Sticky change status |
| p31_out_en_i | input | 1 | Interrupt pin configured as output |
| p31_latch_i | input | 1 | Interrupt pin ordinary output latch |
| p31_o | output | 1 | Interrupt pin drive value |

## Verification
Two pairs of events can land in the same cycle. A detected mismatch can coincide with a mask-register read. An arming write can coincide with a mask read while the status is set. The bench provokes the first case by flipping an enabled pin and asserting the read strobe in exactly the cycle before the status would rise. It expects the status to be set afterwards and the read data to show the old value. It provokes the second case by issuing both strobes together and expects a cleared status with detection re-armed. Random traffic of all strobes against a cycle-level reference model also produces further such overlaps.

// File: rtl/chg_watch_pkg.sv
package chg_watch_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_ARM  = 2'd1,
    ACT_HIT  = 2'd2
  } chg_act_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_mask_reg.sv
module chg_mask_reg #(
  parameter int unsigned NPORT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NPORT-1:0] wdata_i,
  output logic [NPORT-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
endmodule

// File: rtl/chg_core.sv
module chg_core import chg_watch_pkg::*; #(
  parameter int unsigned NPORT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] pins_i,
  input  logic [NPORT-1:0] mask_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic             clr_i,
  output logic             status_o,
  output logic             armed_o,
  output logic             hit_o
);
  logic [NPORT-1:0] snap_q;
  logic             armed_q, status_q;
  chg_act_e         act;

  assign hit_o = armed_q && |((pins_i ^ snap_q) & mask_i);

  // arm beats detection, detection beats disarm/clear
  always_comb begin
    if (arm_i)      act = ACT_ARM;
    else if (hit_o) act = ACT_HIT;
    else            act = ACT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q   <= '0;
      armed_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      case (act)
        ACT_ARM: begin
          snap_q   <= pins_i;
          armed_q  <= 1'b1;
          status_q <= 1'b0;
        end
        ACT_HIT: begin
          status_q <= 1'b1;
          armed_q  <= 1'b0;  // one event per arming
        end
        default: begin
          if (disarm_i) armed_q  <= 1'b0;
          if (clr_i)    status_q <= 1'b0;
        end
      endcase
    end
  end

  assign status_o = status_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/chg_watch.sv
module chg_watch #(
  parameter  int unsigned NPORT       = 7,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW          = NPORT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] port_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_m_i,
  input  logic             msk_wr_i,
  input  logic             msk_rd_i,
  input  logic [RW-1:0]    msk_wdata_i,
  output logic [RW-1:0]    msk_rdata_o,
  output logic             status_o,
  input  logic             p31_out_en_i,
  input  logic             p31_latch_i,
  output logic             p31_o
);
  logic [NPORT-1:0] pins_s, mask;
  logic             arm, disarm, msk_acc, armed, hit, status;

  assign arm     = cfg_wr_i & cfg_m_i;
  assign disarm  = cfg_wr_i & ~cfg_m_i;
  assign msk_acc = msk_wr_i | msk_rd_i;

  chg_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (pins_s)
  );

  chg_mask_reg #(.NPORT(NPORT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (msk_wr_i),
    .wdata_i(msk_wdata_i[NPORT-1:0]),
    .mask_o (mask)
  );

  chg_core #(.NPORT(NPORT)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins_s),
    .mask_i  (mask),
    .arm_i   (arm),
    .disarm_i(disarm),
    .clr_i   (msk_acc),
    .status_o(status),
    .armed_o (armed),
    .hit_o   (hit)
  );

  assign msk_rdata_o = {status, mask};
  assign status_o    = status;
  assign p31_o       = p31_out_en_i ? status : p31_latch_i;
endmodule

// File: rtl/chg_watch_chk.sv
module chg_watch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_wr_i,
  input logic cfg_m_i,
  input logic msk_wr_i,
  input logic msk_rd_i,
  input logic status_o,
  input logic armed_i,
  input logic hit_i
);
  logic arm_w, acc_w;
  assign arm_w = cfg_wr_i && cfg_m_i;
  assign acc_w = msk_wr_i || msk_rd_i;

  a_r3_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_w |=> (!status_o && armed_i));

  a_r4_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !cfg_m_i) |=> !armed_i);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !acc_w && !arm_w) |=> status_o);

  a_r7_access_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_w && !arm_w && !hit_i) |=> !status_o);

  a_r9_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !arm_w) |=> (status_o && !armed_i));

  a_r9_rise_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(armed_i));

  a_r11_hit_over_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && acc_w && !arm_w) |=> status_o);
endmodule

bind chg_watch chg_watch_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_wr_i(cfg_wr_i),
  .cfg_m_i (cfg_m_i),
  .msk_wr_i(msk_wr_i),
  .msk_rd_i(msk_rd_i),
  .status_o(status_o),
  .armed_i (armed),
  .hit_i   (hit)
);

// File: tb/chg_watch_tb_top.sv
module chg_watch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] port = '0;
  logic       cfg_wr = 0, cfg_m = 0, msk_wr = 0, msk_rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       status, p31_en = 0, p31_lat = 0, p31;
  int         n_chk = 0, n_fail = 0;
  logic       done = 0;

  always #5 clk = ~clk;

  chg_watch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port),
    .cfg_wr_i(cfg_wr), .cfg_m_i(cfg_m), .msk_wr_i(msk_wr), .msk_rd_i(msk_rd),
    .msk_wdata_i(wdata), .msk_rdata_o(rdata), .status_o(status),
    .p31_out_en_i(p31_en), .p31_latch_i(p31_lat), .p31_o(p31)
  );

  // reference model built from the requirements
  logic [6:0] m_s1, m_s2, m_snap, m_mask;
  logic       m_armed, m_status;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_mask <= '0;
      m_armed <= 0; m_status <= 0;
    end else begin
      m_s1 <= port; m_s2 <= m_s1;
      if (msk_wr) m_mask <= wdata[6:0];
      if (cfg_wr && cfg_m) begin
        m_snap <= m_s2; m_armed <= 1; m_status <= 0;
      end else if (m_armed && |((m_s2 ^ m_snap) & m_mask)) begin
        m_status <= 1; m_armed <= 0;
      end else begin
        if (cfg_wr && !cfg_m) m_armed <= 0;
        if (msk_wr || msk_rd) m_status <= 0;
      end
    end
  end

  function automatic logic exp_p31(input logic en, input logic lat, input logic st);
    return en ? st : lat;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      cfg_wr = 0; msk_wr = 0; msk_rd = 0;
    end
  endtask

  task automatic do_arm(input logic m);
    cfg_wr = 1; cfg_m = m; step();
  endtask

  task automatic do_mwrite(input logic [7:0] d);
    msk_wr = 1; wdata = d; step();
  endtask

  task automatic do_read(input string tag, input logic [7:0] exp);
    msk_rd = 1; #1;
    chk(tag, rdata, exp);
    @(negedge clk);
    step();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #23 rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 rdata", rdata, 8'h00);
    chk("R10 p31 latch", p31, 0);

    do_mwrite(8'h0F);
    step(3);
    do_arm(1);
    chk("R3 arm clears", status, 0);

    port[5] = 1; step(4);
    chk("R5 masked pin ignored", status, 0);

    port[1] = 1; step(2);
    chk("R2 latency not yet", status, 0);
    step(1);
    chk("R2 R5 enabled pin sets", status, 1);

    port[1] = 0; step(3);
    chk("R6 sticky after return", status, 1);
    p31_en = 1; p31_lat = 0; #1;
    chk("R10 p31 carries status", p31, 1);
    p31_en = 0; p31_lat = 1; #1;
    chk("R10 p31 carries latch", p31, 1);
    p31_lat = 0;

    do_read("R7 first read", 8'h8F);
    do_read("R7 second read", 8'h0F);

    port[0] = 1; step(4);
    chk("R9 one-shot", status, 0);

    do_arm(1);
    do_arm(1);
    chk("R3 re-arm", status, 0);
    do_mwrite(8'h8F); step(2);
    chk("R8 bit7 write", status, 0);
    chk("R8 rdata", rdata, 8'h0F);

    do_arm(0);
    port[2] = 1; step(4);
    chk("R4 disarmed", status, 0);

    step(2); do_arm(1);
    port[3] = 1; step(1); port[3] = 0; step(4);
    chk("R2 one-clock pulse", status, 1);

    cfg_wr = 1; cfg_m = 1; msk_rd = 1; step();
    chk("R11 arm over clear", status, 0);

    port[0] = 0; step(2);
    msk_rd = 1; #1;
    chk("R11 read data before hit", rdata, 8'h0F);
    step();
    chk("R11 hit over clear", status, 1);
    do_read("R7 clear after collision", 8'h8F);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) port[$urandom_range(6)] ^= 1'b1;
      msk_wr = ($urandom_range(19) == 0);
      wdata  = 8'($urandom);
      msk_rd = ($urandom_range(9) == 0);
      cfg_wr = ($urandom_range(14) == 0);
      cfg_m  = ($urandom_range(3) != 0);
      p31_en = 1'($urandom);
      p31_lat = 1'($urandom);
      @(posedge clk); @(negedge clk);
      chk("R5 R6 R9 R11 rand status", status, m_status);
      chk("R7 rand rdata", rdata, {m_status, m_mask});
      chk("R10 rand p31", p31, exp_p31(p31_en, p31_lat, m_status));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule